// File: doc/BRIEF.md
# SDRAM Read Latency and Byte Mask Pipeline

This block sits on the data side of a single-data-rate SDRAM controller. The command side tells it when a read burst starts, how many beats the burst holds, and when the burst is halted by a precharge or burst stop. It also says when a write beat goes out. From these the block tracks which read beats are still due and delays each issued beat by the programmed CAS latency of 2 or 3 cycles. It then models the cycle in which the memory drives each byte lane of the bus. It returns the captured read data with a valid strobe.

Byte masks act with two different delays. On reads, a lane mask takes effect two clocks after it is sampled, whatever the latency. On writes, the lane is blocked in the same cycle the mask is sampled.

A write beat flushes every read beat still in flight. A halt only stops new beats from being issued, so beats already issued still drain.

Top module: `sdram_rdlat_pipe`

## Requirements
- R1: After reset the latency is 3 (`lat3`=1), `beats_left`=0, `dq_oe`=0, `rd_valid`=0 and `cfg_err`=0.
- R2: A write of the configuration with code 3'b010 selects latency 2 (`lat3`=0), and code 3'b011 selects latency 3 (`lat3`=1). The new value is visible after the sampling edge.
- R3: Any other configuration code raises `cfg_err` for exactly one cycle and leaves `lat3` unchanged.
- R4: A read beat issued at edge k drives the bus (`dq_oe` non-zero, `rd_valid`=1) in the cycle that ends at edge k+L, where L is the latency. Every input is sampled on the rising edge.
- R5: A read command of length N (0 is taken as 1) issues N beats on consecutive edges. `beats_left` reads N-1 after the command edge and then counts down by one per edge to 0.
- R6: A `dqm` bit sampled at edge t clears that lane's `dq_oe` bit in the cycle ending at edge t+2, for both latencies. `dq_oe` bit i gates byte i (bits 8i+7..8i) of `rd_data`. `rd_valid` is 1 only when at least one lane is driven.
- R7: While `wr_cmd` is high, `wr_be` equals the inverse of `dqm` in the same cycle, and `wr_dout` carries `wr_din` with the blocked bytes zeroed. With `wr_cmd` low, `wr_be` is 0.
- R8: `rd_halt` sampled at edge k stops issuing beats (`beats_left`=0 after that edge). Beats issued at earlier edges still drive the bus, so the bus goes quiet from the cycle after edge k+L-1.
- R9: `wr_cmd` sampled at edge k removes all in-flight read beats. `dq_oe`=0 and `rd_valid`=0 from that edge on.
- R10: A read command during a burst replaces the remaining beats of the old burst. Old beats already issued still appear, and the new burst's beats follow them with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Latency configuration write |
| cfg_code | input | 3 | Latency code (010 = 2, 011 = 3) |
| cfg_err | output | 1 | One-cycle flag for a reserved code |
| lat3 | output | 1 | Current latency is 3 (else 2) |
| rd_cmd | input | 1 | Start of a read burst |
| rd_len | input | LENW | Burst length in beats |
| rd_halt | input | 1 | Precharge or burst stop |
| wr_cmd | input | 1 | Write beat this cycle |
| dqm | input | LANES | Per-lane mask |
| beats_left | output | LENW | Read beats still to issue |
| dq_in | input | DW | Data from the memory |
| dq_oe | output | LANES | Lanes driven by the memory this cycle |
| rd_data | output | DW | Captured read data, masked lanes zero |
| rd_valid | output | 1 | Read beat delivered |
| wr_din | input | DW | Write data from the requester |
| wr_dout | output | DW | Write data toward the bus, blocked lanes zero |
| wr_be | output | LANES | Lanes written this cycle |

## Verification
The hardest case is the one where a read mask, a halt or a second read lands in the middle of a burst. The effect appears one or two cycles after the stimulus, and its delay depends on the latency. The directed tests drive that stimulus from the observation cycle of a chosen beat. They then predict the affected cycle by counting edges from the command edge. A table of latency, length and mask combinations covers the fixed-mask cases at both latencies, including a fully masked burst.

// File: rtl/sdram_rdlat_pipe.sv
module sdram_rdlat_pipe #(
  parameter int DW    = 32,
  parameter int LANES = 4,
  parameter int LENW  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_code,
  output logic             cfg_err,
  output logic             lat3,
  input  logic             rd_cmd,
  input  logic [LENW-1:0]  rd_len,
  input  logic             rd_halt,
  input  logic             wr_cmd,
  input  logic [LANES-1:0] dqm,
  output logic [LENW-1:0]  beats_left,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] dq_oe,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic [DW-1:0]    wr_din,
  output logic [DW-1:0]    wr_dout,
  output logic [LANES-1:0] wr_be
);
  localparam int LW     = DW / LANES;
  localparam int MAXLAT = 3;

  logic [MAXLAT-1:0] sr;
  logic [LANES-1:0]  m1, m2;
  logic [LENW-1:0]   cnt;

  wire code_ok = (cfg_code == 3'b010) || (cfg_code == 3'b011);
  wire stop    = rd_halt | wr_cmd;
  wire rd_go   = rd_cmd & ~stop;
  wire issue   = rd_go | ((cnt != '0) & ~stop);
  wire beat    = lat3 ? sr[MAXLAT-1] : sr[MAXLAT-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat3    <= 1'b1;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_we & ~code_ok;
      if (cfg_we && code_ok) lat3 <= cfg_code[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (stop)       cnt <= '0;
    else if (rd_go)      cnt <= (rd_len == '0) ? '0 : rd_len - LENW'(1);
    else if (cnt != '0)  cnt <= cnt - LENW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
      m1 <= '0;
      m2 <= '0;
    end else begin
      sr <= wr_cmd ? '0 : {sr[MAXLAT-2:0], issue};
      m1 <= dqm;
      m2 <= m1;
    end
  end

  assign beats_left = cnt;
  assign dq_oe      = {LANES{beat}} & ~m2;
  assign rd_valid   = |dq_oe;
  assign wr_be      = {LANES{wr_cmd}} & ~dqm;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_data[i*LW +: LW] = dq_in[i*LW +: LW]  & {LW{dq_oe[i]}};
    assign wr_dout[i*LW +: LW] = wr_din[i*LW +: LW] & {LW{wr_be[i]}};
  end

  p_cfg_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_code == 3'b010) |=> (!lat3 && !cfg_err));

  p_err_keeps_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(lat3));

  p_len_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !rd_halt && !wr_cmd && rd_len > LENW'(1)) |=> beats_left == $past(rd_len) - LENW'(1));

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beats_left != '0 && !rd_cmd && !rd_halt && !wr_cmd) |=> beats_left == $past(beats_left) - LENW'(1));

  p_halt_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_halt |=> beats_left == '0);

  p_wr_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (dq_oe == '0 && !rd_valid));
endmodule

// File: tb/sdram_rdlat_pipe_tb.sv
`timescale 1ns/1ps
module sdram_rdlat_pipe_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, rd_cmd = 0, rd_halt = 0, wr_cmd = 0;
  logic [2:0] cfg_code = 0;
  logic [8:0] rd_len = 0;
  logic [3:0] dqm = 0;
  logic [31:0] dq_in = 0, wr_din = 0;
  logic cfg_err, lat3, rd_valid;
  logic [8:0] beats_left;
  logic [3:0] dq_oe, wr_be;
  logic [31:0] rd_data, wr_dout;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_rdlat_pipe dut_i (.clk, .rst_n, .cfg_we, .cfg_code, .cfg_err, .lat3,
    .rd_cmd, .rd_len, .rd_halt, .wr_cmd, .dqm, .beats_left, .dq_in, .dq_oe,
    .rd_data, .rd_valid, .wr_din, .wr_dout, .wr_be);

  // {code[2:0], len[3:0], mask[3:0]}
  localparam logic [10:0] VEC [6] = '{
    {3'b010, 4'd2, 4'b0000}, {3'b011, 4'd4, 4'b0000}, {3'b010, 4'd3, 4'b0101},
    {3'b011, 4'd1, 4'b1111}, {3'b011, 4'd3, 4'b1000}, {3'b010, 4'd5, 4'b0011}};

  function automatic logic [31:0] ex(input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_lat(input logic [2:0] code);
    cfg_we = 1; cfg_code = code; tick; cfg_we = 0;
  endtask

  task automatic rd_start(input int n);
    rd_cmd = 1; rd_len = 9'(n); tick; rd_cmd = 0;
  endtask

  task automatic obs(input logic [3:0] e, input string rq);
    dq_in = 32'hC3A5_5A3C ^ {24'h0, 8'($time)}; #1;
    chk(dq_oe == e && rd_valid == (e != 0) && rd_data == (dq_in & ex(e)), rq,
        {27'h0, rd_valid, dq_oe, rd_data}, {27'h0, e != 0, e, dq_in & ex(e)});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick; tick; rst_n = 1; #1;
    // R1 reset state
    chk(lat3 && beats_left == 0 && dq_oe == 0 && !rd_valid && !cfg_err, "R1",
        {lat3, beats_left, dq_oe, rd_valid, cfg_err}, {1'b1, 9'd0, 4'd0, 1'b0, 1'b0});

    // R2 / R3 configuration
    set_lat(3'b010); chk(!lat3 && !cfg_err, "R2", {lat3, cfg_err}, 2'b00);
    set_lat(3'b101); chk(!lat3 && cfg_err, "R3", {lat3, cfg_err}, 2'b01);
    tick; chk(!cfg_err, "R3", cfg_err, 0);
    set_lat(3'b011); chk(lat3 && !cfg_err, "R2", {lat3, cfg_err}, 2'b10);
    set_lat(3'b000); chk(lat3 && cfg_err, "R3", {lat3, cfg_err}, 2'b11);

    // R4 / R6 table: latency, length, fixed mask
    for (int v = 0; v < 6; v++) begin
      automatic int L = VEC[v][8] ? 3 : 2;
      automatic int n = int'(VEC[v][7:4]);
      automatic logic [3:0] m = VEC[v][3:0];
      set_lat(VEC[v][10:8]);
      dqm = m;
      rd_start(n);
      for (int c = 0; c <= L + n; c++) begin
        obs((c >= L - 1 && c < L - 1 + n) ? ~m : 4'h0, "R4/R6 table");
        tick;
      end
      dqm = 0;
    end

    // R5 countdown and length zero
    set_lat(3'b011);
    rd_start(4);
    for (int c = 0; c < 4; c++) begin
      chk(beats_left == 9'(3 - c), "R5 countdown", beats_left, 9'(3 - c));
      tick;
    end
    tick; tick; tick;
    rd_start(0);
    for (int c = 0; c < 5; c++) begin
      if (c == 0) chk(beats_left == 0, "R5 len0", beats_left, 0);
      obs(c == 2 ? 4'hF : 4'h0, "R5 len0 single beat");
      tick;
    end

    // R6 mid-burst mask pulse, latency 3
    rd_start(6);
    for (int c = 0; c < 10; c++) begin
      dqm = (c == 1) ? 4'b0010 : 4'b0000;
      obs((c >= 2 && c <= 7) ? ((c == 3) ? 4'b1101 : 4'hF) : 4'h0, "R6 mask delay");
      tick;
    end
    dqm = 0;

    // R6 mid-burst mask pulse, latency 2
    set_lat(3'b010);
    rd_start(5);
    for (int c = 0; c < 8; c++) begin
      dqm = (c == 0) ? 4'b1000 : 4'b0000;
      obs((c >= 1 && c <= 5) ? ((c == 2) ? 4'b0111 : 4'hF) : 4'h0, "R6 mask delay L2");
      tick;
    end
    dqm = 0;

    // R7 write mask, same cycle
    wr_din = 32'h1122_3344; dqm = 4'b0110; wr_cmd = 1; #1;
    chk(wr_be == 4'b1001 && wr_dout == 32'h1100_0044, "R7", {wr_be, wr_dout}, {4'b1001, 32'h1100_0044});
    dqm = 4'b0001; #1;
    chk(wr_be == 4'b1110 && wr_dout == 32'h1122_3300, "R7", {wr_be, wr_dout}, {4'b1110, 32'h1122_3300});
    tick; wr_cmd = 0; dqm = 0; #1;
    chk(wr_be == 0 && wr_dout == 0, "R7 idle", {wr_be, wr_dout}, 0);
    tick; tick;

    // R9 write flushes in-flight reads, latency 3
    set_lat(3'b011);
    rd_start(4);
    for (int c = 0; c < 7; c++) begin
      if (c == 3) wr_cmd = 1;
      else wr_cmd = 0;
      obs((c == 2 || c == 3) ? 4'hF : 4'h0, "R9 write flush");
      if (c == 4) chk(beats_left == 0, "R9 count", beats_left, 0);
      tick;
    end
    wr_cmd = 0;

    // R8 halt, latency 3
    rd_start(8);
    for (int c = 0; c < 7; c++) begin
      rd_halt = (c == 1);
      obs((c == 2 || c == 3) ? 4'hF : 4'h0, "R8 halt L3");
      if (c == 2) chk(beats_left == 0, "R8 count", beats_left, 0);
      tick;
    end
    rd_halt = 0;

    // R8 halt, latency 2
    set_lat(3'b010);
    rd_start(8);
    for (int c = 0; c < 6; c++) begin
      rd_halt = (c == 1);
      obs((c == 1 || c == 2) ? 4'hF : 4'h0, "R8 halt L2");
      tick;
    end
    rd_halt = 0;

    // R10 read interrupts read, latency 3
    set_lat(3'b011);
    rd_start(4);
    for (int c = 0; c < 8; c++) begin
      if (c == 1) begin rd_cmd = 1; rd_len = 9'd1; end
      else rd_cmd = 0;
      obs((c >= 2 && c <= 4) ? 4'hF : 4'h0, "R10 interrupt");
      tick;
    end
    rd_cmd = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule